// File: doc/BRIEF.md
# Per-Queue Token-Bucket Transmit Shaper

This block limits how fast each of several transmit queues may send. Every queue owns a bucket of credit counted in bits. All buckets share one base tick, which comes from counting core clock cycles up to a programmed limit. Each queue also counts its own number of base ticks between refills, so its rate is set by three values: the refill amount, the refill period in ticks, and the bucket ceiling. With a base tick of 100 ns and a period of 1000 ticks, one unit of refill amount is worth 10 kbps.

Each queue presents a valid flag and a frame length in bytes. A queue is eligible when its bucket holds at least eight bits per byte of the frame. The block grants the lowest-numbered eligible queue with a registered one-hot grant pulse, and takes the frame's cost from that bucket on the same clock edge. A small write-only register port sets the global mode bits, the tick limit and the settings for each queue. Per-queue shaping is active only while both legacy mode bits are clear. In every other mode all queues pass unshaped.

Top module: `txq_shaper`

## Requirements
- R1: The control register (address 0x00) holds a legacy enable in bit 0 and a legacy select in bit 3, and both reset to 1. Shaping is active only when both bits are 0. In any other setting every valid request is eligible whatever its bucket holds, and the buckets neither refill nor drain.
- R2: The tick-limit register (address 0x04, bits 15:0, value N) makes one base tick every N core cycles. A value of 0 acts as 1.
- R3: The refill register of queue q (address 0x20 + 4·q) holds the amount in bits 18:0 and the period P in bits 29:20. While shaping is active the amount is added once every P base ticks (0 acts as 1). The tick count for the queue restarts when its refill register is written or when shaping turns on.
- R4: A write to a refill register whose amount field is zero is ignored, and the previous amount and period stay in force.
- R5: The ceiling register of queue q (address 0x40 + 4·q, bits 30:0) caps the bucket, and a refill never raises the bucket above it.
- R6: When shaping turns on, every bucket is loaded with its ceiling.
- R7: While shaping is active, a queue is eligible when its request is valid and its bucket holds at least 8 × length bits. A grant subtracts 8 × length from that bucket.
- R8: Grants are registered. Bit q of the one-hot grant output rises on the clock edge after queue q is seen eligible. When several queues are eligible, the lowest-numbered one wins, and at most one grant is issued per cycle.
- R9: A queue whose grant is high in the current cycle is not granted on the next edge, so the requester has one cycle to withdraw or change its request.
- R10: After reset, no grant is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte address |
| wr_data | input | 32 | Register write data |
| req_vld | input | NQ | Request valid, one bit per queue |
| req_len | input | NQ·LEN_W | Frame length in bytes, LEN_W bits per queue, queue 0 in the low bits |
| gnt | output | NQ | One-hot grant pulse |

## Verification
The grant logic is tested with three kinds of pattern. The first sends oversized frames in the unshaped modes, which confirms that only the mode with both bits clear enforces credit. The second is a pair of simultaneous requests in which the lower queue lacks credit, which separates priority order from eligibility. The third is a request held high for several cycles, which exposes the one-cycle lockout. Shaped runs use frame sizes one byte above and exactly at the saturated ceiling to locate both the ceiling and the comparison boundary. A zero-amount write followed by a drain-and-wait shows whether the refill stream continued. A long run with one-byte frames against an eight-bit ceiling measures the grant spacing, which must equal the tick limit times the period.

// File: rtl/shaper_pkg.sv
package shaper_pkg;
  localparam logic [7:0] A_CTRL    = 8'h00;
  localparam logic [7:0] A_TICK    = 8'h04;
  localparam logic [7:0] A_REFILL  = 8'h20;
  localparam logic [7:0] A_CEIL    = 8'h40;
  localparam int         B_LIM_EN  = 0;
  localparam int         B_LIM_SEL = 3;
  localparam int         AMT_W     = 19;
  localparam int         PER_W     = 10;
  localparam int         PER_LSB   = 20;
  localparam int         CEIL_W    = 31;
  localparam int         TICK_W    = 16;
endpackage

// File: rtl/shaper_tick.sv
module shaper_tick #(
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [TICK_W-1:0] limit,
  output logic              tick
);
  logic [TICK_W-1:0] cnt;
  logic [TICK_W-1:0] last;

  assign last = (limit == '0) ? '0 : limit - 1'b1;
  assign tick = (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || clr || tick) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/shaper_bucket.sv
module shaper_bucket #(
  parameter int AMT_W  = 19,
  parameter int PER_W  = 10,
  parameter int CEIL_W = 31,
  parameter int COST_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shape_on,
  input  logic              en_rise,
  input  logic              tick,
  input  logic              cfg_wr,
  input  logic [AMT_W-1:0]  amt,
  input  logic [PER_W-1:0]  per,
  input  logic [CEIL_W-1:0] ceil,
  input  logic              vld,
  input  logic [COST_W-1:0] cost,
  input  logic              take,
  output logic              elig
);
  localparam int SUM_W = CEIL_W + 2;

  logic [PER_W-1:0]  pcnt;
  logic [PER_W-1:0]  plast;
  logic              fire;
  logic [CEIL_W-1:0] level;
  logic [SUM_W-1:0]  sum;
  logic              enough;

  assign plast  = (per == '0) ? '0 : per - 1'b1;
  assign fire   = shape_on && tick && (pcnt == plast);
  assign enough = ({{(SUM_W-CEIL_W){1'b0}}, level} >= {{(SUM_W-COST_W){1'b0}}, cost});
  assign elig   = vld && (!shape_on || enough);

  always_comb begin
    sum = {{(SUM_W-CEIL_W){1'b0}}, level};
    if (take) sum = sum - {{(SUM_W-COST_W){1'b0}}, cost};
    if (fire) sum = sum + {{(SUM_W-AMT_W){1'b0}}, amt};
  end

  always_ff @(posedge clk) begin
    if (rst || cfg_wr || en_rise)  pcnt <= '0;
    else if (shape_on && tick)     pcnt <= fire ? '0 : pcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)            level <= '1;
    else if (en_rise)   level <= ceil;
    else if (shape_on)  level <= (sum > {2'b00, ceil}) ? ceil : sum[CEIL_W-1:0];
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (shape_on && take) |-> enough);  // R7
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    (!shape_on && $past(!shape_on)) |-> (level == $past(level)));  // R1
  AST_CEIL_CAP: assert property (@(posedge clk) disable iff (rst)
    (shape_on && $past(shape_on) && $stable(ceil) && level > $past(level)) |-> (level <= ceil));  // R5
endmodule

// File: rtl/shaper_arb.sv
module shaper_arb #(
  parameter int NQ = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NQ-1:0] vld,
  input  logic [NQ-1:0] elig,
  output logic [NQ-1:0] pick,
  output logic [NQ-1:0] gnt_q
);
  logic [NQ-1:0] cand;

  assign cand = elig & ~gnt_q;

  always_comb begin
    pick = '0;
    for (int i = NQ - 1; i >= 0; i--) begin
      if (cand[i]) pick = NQ'(1) << i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) gnt_q <= '0;
    else     gnt_q <= pick;
  end

  AST_ONE_GNT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_q));  // R8
  AST_NO_B2B: assert property (@(posedge clk) disable iff (rst)
    ((gnt_q & $past(gnt_q)) == '0));  // R9
  AST_GNT_HAD_REQ: assert property (@(posedge clk) disable iff (rst)
    (gnt_q != '0) |-> ((gnt_q & $past(vld)) != '0));  // R8
endmodule

// File: rtl/txq_shaper.sv
module txq_shaper
  import shaper_pkg::*;
#(
  parameter int NQ    = 8,
  parameter int LEN_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [NQ-1:0]     req_vld,
  input  logic [NQ*LEN_W-1:0] req_len,
  output logic [NQ-1:0]     gnt
);
  localparam int         QW     = (NQ > 1) ? $clog2(NQ) : 1;
  localparam int         COST_W = LEN_W + 3;
  localparam logic [7:0] SPAN   = 8'(4 * NQ);

  logic              lim_en, lim_sel, shape_d;
  logic              shape_on, en_rise, tick;
  logic [TICK_W-1:0] tick_n;
  logic [AMT_W-1:0]  amt_q  [NQ];
  logic [PER_W-1:0]  per_q  [NQ];
  logic [CEIL_W-1:0] ceil_q [NQ];
  logic [7:0]        rf_off, cl_off;
  logic              rf_hit, cl_hit;
  logic [QW-1:0]     rf_idx, cl_idx;
  logic [NQ-1:0]     elig, pick;

  assign shape_on = !lim_en && !lim_sel;
  assign en_rise  = shape_on && !shape_d;
  assign rf_off   = wr_addr - A_REFILL;
  assign cl_off   = wr_addr - A_CEIL;
  assign rf_hit   = wr_en && (wr_addr >= A_REFILL) && (rf_off < SPAN) &&
                    (wr_data[AMT_W-1:0] != '0);
  assign cl_hit   = wr_en && (wr_addr >= A_CEIL) && (cl_off < SPAN);
  assign rf_idx   = rf_off[2 +: QW];
  assign cl_idx   = cl_off[2 +: QW];

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_en  <= 1'b1;
      lim_sel <= 1'b1;
      tick_n  <= TICK_W'(12);
      shape_d <= 1'b0;
    end else begin
      shape_d <= shape_on;
      if (wr_en && wr_addr == A_CTRL) begin
        lim_en  <= wr_data[B_LIM_EN];
        lim_sel <= wr_data[B_LIM_SEL];
      end
      if (wr_en && wr_addr == A_TICK) tick_n <= wr_data[TICK_W-1:0];
    end
  end

  shaper_tick #(.TICK_W(TICK_W)) tick_i (
    .clk(clk), .rst(rst), .clr(en_rise), .limit(tick_n), .tick(tick)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic cfg_wr;
    assign cfg_wr = rf_hit && (rf_idx == QW'(q));

    always_ff @(posedge clk) begin
      if (rst) begin
        amt_q[q]  <= AMT_W'(1);
        per_q[q]  <= PER_W'(1000);
        ceil_q[q] <= '1;
      end else begin
        if (cfg_wr) begin
          amt_q[q] <= wr_data[AMT_W-1:0];
          per_q[q] <= wr_data[PER_LSB +: PER_W];
        end
        if (cl_hit && cl_idx == QW'(q)) ceil_q[q] <= wr_data[CEIL_W-1:0];
      end
    end

    shaper_bucket #(
      .AMT_W(AMT_W), .PER_W(PER_W), .CEIL_W(CEIL_W), .COST_W(COST_W)
    ) bkt_i (
      .clk(clk), .rst(rst), .shape_on(shape_on), .en_rise(en_rise),
      .tick(tick), .cfg_wr(cfg_wr), .amt(amt_q[q]), .per(per_q[q]),
      .ceil(ceil_q[q]), .vld(req_vld[q]),
      .cost({req_len[q*LEN_W +: LEN_W], 3'b000}),
      .take(pick[q]), .elig(elig[q])
    );
  end

  shaper_arb #(.NQ(NQ)) arb_i (
    .clk(clk), .rst(rst), .vld(req_vld), .elig(elig), .pick(pick), .gnt_q(gnt)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (gnt == '0));  // R10
endmodule

// File: tb/txq_shaper_tb_top.sv
module txq_shaper_tb_top;
  localparam int NQ    = 8;
  localparam int LEN_W = 14;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                wr_en = 1'b0;
  logic [7:0]          wr_addr = '0;
  logic [31:0]         wr_data = '0;
  logic [NQ-1:0]       req_vld = '0;
  logic [NQ*LEN_W-1:0] req_len = '0;
  logic [NQ-1:0]       gnt;
  int                  n_chk = 0;
  int                  n_bad = 0;

  always #4 clk = ~clk;

  txq_shaper #(.NQ(NQ), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_vld(req_vld), .req_len(req_len), .gnt(gnt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_req(input int q, input int len);
    req_len[q*LEN_W +: LEN_W] = LEN_W'(len);
    req_vld[q] = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // returns cycles until gnt[q] seen high, or -1; drops the request when seen
  task automatic wait_gnt(input int q, input int max, output int n);
    n = -1;
    for (int i = 0; i < max; i++) begin
      @(negedge clk);
      if (gnt[q]) begin n = i + 1; req_vld[q] = 1'b0; break; end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(gnt == '0, "R10 no grant after reset", int'(gnt), 0);
  endtask

  task automatic t_unshaped();
    int n;
    set_req(3, 16383);
    wait_gnt(3, 4, n);
    chk(n == 1, "R1 reset mode unshaped", n, 1);
    @(negedge clk);
    set_req(2, 5000); set_req(5, 5000);
    @(negedge clk);
    chk(gnt == 8'b0000_0100, "R8 lowest queue wins", int'(gnt), 4);
    req_vld[2] = 1'b0;
    @(negedge clk);
    chk(gnt == 8'b0010_0000, "R8 next queue follows", int'(gnt), 32);
    req_vld[5] = 1'b0;
    wr(8'h00, 32'h1);
    set_req(0, 12000);
    wait_gnt(0, 4, n);
    chk(n == 1, "R1 bit0 only stays unshaped", n, 1);
    wr(8'h00, 32'h8);
    set_req(0, 12000);
    wait_gnt(0, 4, n);
    chk(n == 1, "R1 bit3 only stays unshaped", n, 1);
    wr(8'h00, 32'h9);
  endtask

  task automatic t_lockout();
    int cnt = 0;
    int prev = 0;
    int dbl = 0;
    idle(2);
    set_req(1, 4);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (gnt[1]) cnt++;
      if (gnt[1] && prev == 1) dbl++;
      prev = int'(gnt[1]);
    end
    req_vld[1] = 1'b0;
    chk(cnt == 3, "R9 held request grant count", cnt, 3);
    chk(dbl == 0, "R9 no back-to-back grant", dbl, 0);
  endtask

  task automatic t_shaped();
    int n;
    idle(2);
    wr(8'h04, 32'd1);
    wr(8'h20, (32'd1000 << 20) | 32'd8);
    wr(8'h40, 32'd100);
    wr(8'h00, 32'h0);
    idle(3);
    set_req(0, 10);
    wait_gnt(0, 4, n);
    chk(n == 1, "R6 R7 full bucket grants 80 bits", n, 1);
    @(negedge clk);
    set_req(0, 3); set_req(1, 1);
    @(negedge clk);
    chk(gnt == 8'b0000_0010, "R8 R7 ineligible low queue skipped", int'(gnt), 2);
    req_vld[1] = 1'b0;
    wait_gnt(0, 50, n);
    chk(n == -1, "R7 24 bits exceed 20 left", n, -1);
    req_len[0 +: LEN_W] = LEN_W'(2);
    wait_gnt(0, 4, n);
    chk(n == 1, "R7 16 bits fit 20 left", n, 1);
    wr(8'h20, (32'd2 << 20) | 32'd8);
    idle(300);
    set_req(0, 13);
    wait_gnt(0, 20, n);
    chk(n == -1, "R5 bucket capped at ceiling 100", n, -1);
    req_len[0 +: LEN_W] = LEN_W'(12);
    wait_gnt(0, 4, n);
    chk(n == 1, "R5 R7 96 bits fit saturated bucket", n, 1);
    wr(8'h20, (32'd1000 << 20));
    set_req(0, 12);
    wait_gnt(0, 40, n);
    chk(n > 1 && n <= 40, "R4 zero amount write ignored, R3 refill continues", n, 20);
    wr(8'h20, (32'd1000 << 20) | 32'd1);
    set_req(0, 12);
    wait_gnt(0, 10, n);
    chk(n == -1, "R3 slow refill keeps queue waiting", n, -1);
    req_vld[0] = 1'b0;
    wr(8'h00, 32'h9);
    wr(8'h00, 32'h0);
    idle(3);
    set_req(0, 12);
    wait_gnt(0, 4, n);
    chk(n == 1, "R6 enable reloads ceiling", n, 1);
  endtask

  task automatic t_rate();
    int times[8];
    int k = 0;
    wr(8'h00, 32'h9);
    wr(8'h04, 32'd4);
    wr(8'h20, (32'd3 << 20) | 32'd8);
    wr(8'h40, 32'd8);
    wr(8'h00, 32'h0);
    idle(2);
    set_req(0, 1);
    for (int i = 0; i < 70; i++) begin
      @(negedge clk);
      if (gnt[0] && k < 8) begin times[k] = i; k++; end
    end
    req_vld[0] = 1'b0;
    chk(k >= 5, "R2 R3 grants in 70 cycles", k, 6);
    for (int j = 2; j < 5; j++)
      chk(k < 5 || times[j] - times[j-1] == 12, "R2 R3 refill spacing", times[j] - times[j-1], 12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_unshaped();
    t_lockout();
    t_shaped();
    t_rate();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule